// File: doc/BRIEF.md
# Prioritised Interrupt Collector with Test Force

This block gathers fifteen interrupt levels (numbered 1 to 15) from on-chip event sources: two serial channels, a shared serial overrun error, a general-purpose timer and a real-time clock timer. Each source sends a one-cycle pulse. The pulse latches a pending bit, and that bit stays set until software clears it. Software reaches four word registers through a single-cycle register port. These are a read-only pending view, a read-write enable mask, a write-only clear strobe and a read-write force register. The force register can drive any of the fifteen levels as a request without any hardware event, which is useful for testing.

The block continuously drives `irq_level`. This is the number of the highest level that is both requested and enabled. A level counts as requested when it is pending or forced. A value of 0 means nothing is requested. There is no external interrupt input and no per-level edge or level selection.

Top module: `irq_hub`

## Requirements
- R1: While `rst_n` is low, and after it is released, pending, mask and force all read 0 and `irq_level` is 0.
- R2: A one-cycle pulse latches a pending bit at the next rising clock edge, and that bit then holds. The pulses map to levels as follows: `ser_a_evt` sets level 4, `ser_b_evt` sets level 5, `ser_ovf_evt` sets level 3, `gpt_evt` sets level 12 and `rtc_evt` sets level 13.
- R3: A write to offset 2 (clear) drops every pending bit whose data bit is 1 and leaves the bits written with 0 unchanged. A read of offset 2 returns 0.
- R4: When a clear and a source pulse hit the same bit in the same cycle, that bit is set after the edge.
- R5: Offset 1 (mask) can be written and read back on bits 15 to 1.
- R6: Offset 3 (force) can be written and read back on bits 15 to 1. A forced bit counts as a request while it stays set, and it never changes the pending register.
- R7: `irq_level` equals the index of the highest set bit of (pending OR force) AND mask. It is 0 when that expression is empty.
- R8: Offset 0 (pending) is read-only. A write to it changes nothing.
- R9: Bit 0 of every register reads 0, whatever was written to it.
- R10: A write takes effect at the rising edge where `bus_wr` is sampled high. Before that edge, `irq_level` still shows the old register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_a_evt | input | 1 | Serial channel A character pulse (level 4) |
| ser_b_evt | input | 1 | Serial channel B character pulse (level 5) |
| ser_ovf_evt | input | 1 | Serial receive overrun pulse (level 3) |
| gpt_evt | input | 1 | General-purpose timer pulse (level 12) |
| rtc_evt | input | 1 | Real-time clock timer pulse (level 13) |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 2 | Register offset: 0 pending, 1 mask, 2 clear, 3 force |
| bus_wdata | input | 16 | Write data, bit n belongs to level n |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_level | output | 4 | Highest enabled requested level, 0 when idle |

## Verification
Two functions can fall in the same cycle: software clearing a pending bit, and a hardware source raising that same bit. The bench provokes the collision by driving the clear write and the source pulse within one clock period. It also provokes a variant where the clear covers every bit. It then reads the pending register and expects the colliding bit to be set and every other bit to be clear. The bench also checks that `irq_level` still names that level when the mask enables everything.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Number of interrupt levels; level 0 is reserved for "no request".
    localparam int IRQ_LEVELS = 15;

    // Register offsets on the word-addressed register port.
    typedef enum logic [1:0] {
        REG_PEND  = 2'd0,
        REG_MASK  = 2'd1,
        REG_CLR   = 2'd2,
        REG_FORCE = 2'd3
    } irqc_reg_e;

    // Default level assignment of the internal sources.
    localparam int LVL_SER_OVF = 3;
    localparam int LVL_SER_A   = 4;
    localparam int LVL_SER_B   = 5;
    localparam int LVL_GPT     = 12;
    localparam int LVL_RTC     = 13;

endpackage

// File: rtl/irqc_src_map.sv
// Places the one-cycle source pulses onto their level positions.
module irqc_src_map #(
    parameter int NUM_LEVELS = irqc_pkg::IRQ_LEVELS,
    parameter int L_SER_OVF  = irqc_pkg::LVL_SER_OVF,
    parameter int L_SER_A    = irqc_pkg::LVL_SER_A,
    parameter int L_SER_B    = irqc_pkg::LVL_SER_B,
    parameter int L_GPT      = irqc_pkg::LVL_GPT,
    parameter int L_RTC      = irqc_pkg::LVL_RTC,
    localparam int VEC_W     = NUM_LEVELS + 1
) (
    input  logic             ser_a_evt,
    input  logic             ser_b_evt,
    input  logic             ser_ovf_evt,
    input  logic             gpt_evt,
    input  logic             rtc_evt,
    output logic [VEC_W-1:0] evt_vec
);

    always_comb begin
        evt_vec            = '0;
        evt_vec[L_SER_OVF] = evt_vec[L_SER_OVF] | ser_ovf_evt;
        evt_vec[L_SER_A]   = evt_vec[L_SER_A]   | ser_a_evt;
        evt_vec[L_SER_B]   = evt_vec[L_SER_B]   | ser_b_evt;
        evt_vec[L_GPT]     = evt_vec[L_GPT]     | gpt_evt;
        evt_vec[L_RTC]     = evt_vec[L_RTC]     | rtc_evt;
    end

endmodule

// File: rtl/irqc_regs.sv
// Pending / mask / force storage with the register port decode.
module irqc_regs #(
    parameter int NUM_LEVELS = irqc_pkg::IRQ_LEVELS,
    localparam int VEC_W     = NUM_LEVELS + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] evt_vec,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [VEC_W-1:0] bus_wdata,
    output logic [VEC_W-1:0] bus_rdata,
    output logic [VEC_W-1:0] pend_q,
    output logic [VEC_W-1:0] mask_q,
    output logic [VEC_W-1:0] frc_q
);
    import irqc_pkg::*;

    // Bit 0 carries no level and is never stored.
    localparam logic [VEC_W-1:0] LVL_BITS = {{NUM_LEVELS{1'b1}}, 1'b0};

    typedef struct packed {
        logic [VEC_W-1:0] pend;
        logic [VEC_W-1:0] mask;
        logic [VEC_W-1:0] frc;
    } state_t;

    state_t st_d, st_q;
    irqc_reg_e sel;
    logic [VEC_W-1:0] wmask;

    assign sel   = irqc_reg_e'(bus_addr);
    assign wmask = bus_wdata & LVL_BITS;

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            unique case (sel)
                REG_MASK:  st_d.mask = wmask;
                REG_CLR:   st_d.pend = st_q.pend & ~wmask;
                REG_FORCE: st_d.frc  = wmask;
                default:   st_d.pend = st_q.pend;
            endcase
        end
        // New events are merged after the clear so a collision keeps the bit.
        st_d.pend = st_d.pend | (evt_vec & LVL_BITS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (sel)
            REG_PEND:  bus_rdata = st_q.pend;
            REG_MASK:  bus_rdata = st_q.mask;
            REG_FORCE: bus_rdata = st_q.frc;
            default:   bus_rdata = '0;
        endcase
    end

    assign pend_q = st_q.pend;
    assign mask_q = st_q.mask;
    assign frc_q  = st_q.frc;

endmodule

// File: rtl/irqc_prio.sv
// Encodes the highest set bit of the request vector as a level number.
module irqc_prio #(
    parameter int NUM_LEVELS = irqc_pkg::IRQ_LEVELS,
    localparam int VEC_W     = NUM_LEVELS + 1,
    localparam int LVL_W     = $clog2(VEC_W)
) (
    input  logic [VEC_W-1:0] req_vec,
    output logic [LVL_W-1:0] level
);

    always_comb begin
        level = '0;
        for (int i = 1; i < VEC_W; i++) begin
            if (req_vec[i]) level = LVL_W'(i);
        end
    end

endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
    parameter int NUM_LEVELS = irqc_pkg::IRQ_LEVELS,
    parameter int L_SER_OVF  = irqc_pkg::LVL_SER_OVF,
    parameter int L_SER_A    = irqc_pkg::LVL_SER_A,
    parameter int L_SER_B    = irqc_pkg::LVL_SER_B,
    parameter int L_GPT      = irqc_pkg::LVL_GPT,
    parameter int L_RTC      = irqc_pkg::LVL_RTC,
    localparam int VEC_W     = NUM_LEVELS + 1,
    localparam int LVL_W     = $clog2(VEC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_a_evt,
    input  logic             ser_b_evt,
    input  logic             ser_ovf_evt,
    input  logic             gpt_evt,
    input  logic             rtc_evt,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [VEC_W-1:0] bus_wdata,
    output logic [VEC_W-1:0] bus_rdata,
    output logic [LVL_W-1:0] irq_level
);

    logic [VEC_W-1:0] evt_vec;
    logic [VEC_W-1:0] pend_q;
    logic [VEC_W-1:0] mask_q;
    logic [VEC_W-1:0] frc_q;
    logic [VEC_W-1:0] req_vec;

    irqc_src_map #(
        .NUM_LEVELS(NUM_LEVELS),
        .L_SER_OVF (L_SER_OVF),
        .L_SER_A   (L_SER_A),
        .L_SER_B   (L_SER_B),
        .L_GPT     (L_GPT),
        .L_RTC     (L_RTC)
    ) u_src (
        .ser_a_evt  (ser_a_evt),
        .ser_b_evt  (ser_b_evt),
        .ser_ovf_evt(ser_ovf_evt),
        .gpt_evt    (gpt_evt),
        .rtc_evt    (rtc_evt),
        .evt_vec    (evt_vec)
    );

    irqc_regs #(
        .NUM_LEVELS(NUM_LEVELS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_vec  (evt_vec),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pend_q   (pend_q),
        .mask_q   (mask_q),
        .frc_q    (frc_q)
    );

    assign req_vec = (pend_q | frc_q) & mask_q;

    irqc_prio #(
        .NUM_LEVELS(NUM_LEVELS)
    ) u_prio (
        .req_vec(req_vec),
        .level  (irq_level)
    );

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
    parameter int NUM_LEVELS = irqc_pkg::IRQ_LEVELS,
    parameter int L_SER_A    = irqc_pkg::LVL_SER_A,
    parameter int L_RTC      = irqc_pkg::LVL_RTC,
    localparam int VEC_W     = NUM_LEVELS + 1,
    localparam int LVL_W     = $clog2(VEC_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_a_evt,
    input logic             rtc_evt,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [VEC_W-1:0] bus_wdata,
    input logic [VEC_W-1:0] bus_rdata,
    input logic [LVL_W-1:0] irq_level,
    input logic [VEC_W-1:0] evt_vec,
    input logic [VEC_W-1:0] pend_q,
    input logic [VEC_W-1:0] frc_q,
    input logic [VEC_W-1:0] mask_q
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (irq_level == '0));

    // R2
    ser_a_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_a_evt |=> pend_q[L_SER_A]);

    // R2
    rtc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_evt |=> pend_q[L_RTC]);

    // R3
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=>
        ((pend_q & $past(bus_wdata & ~evt_vec)) == '0));

    // R4
    collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && bus_wdata[L_SER_A] && ser_a_evt) |=>
        pend_q[L_SER_A]);

    // R8
    pend_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != 2'd2 && evt_vec == '0) |=> (pend_q == $past(pend_q)));

    // R7
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((irq_level == '0) == (((pend_q | frc_q) & mask_q) == '0)));

    // R9
    bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (bus_rdata[0] == 1'b0));

endmodule

bind irq_hub irq_hub_chk #(
    .NUM_LEVELS(NUM_LEVELS),
    .L_SER_A   (L_SER_A),
    .L_RTC     (L_RTC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_a_evt(ser_a_evt),
    .rtc_evt  (rtc_evt),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_level(irq_level),
    .evt_vec  (evt_vec),
    .pend_q   (pend_q),
    .frc_q    (frc_q),
    .mask_q   (mask_q)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;

    localparam logic [15:0] LB = 16'hFFFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_a_evt = 1'b0, ser_b_evt = 1'b0, ser_ovf_evt = 1'b0;
    logic        gpt_evt = 1'b0, rtc_evt = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic [3:0]  irq_level;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // expected state
    logic [15:0] e_pend = '0, e_mask = '0, e_frc = '0;

    always #2 clk = ~clk;

    irq_hub uut (
        .clk(clk), .rst_n(rst_n),
        .ser_a_evt(ser_a_evt), .ser_b_evt(ser_b_evt), .ser_ovf_evt(ser_ovf_evt),
        .gpt_evt(gpt_evt), .rtc_evt(rtc_evt),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_level(irq_level)
    );

    function automatic int top_bit(input logic [15:0] v);
        int r = 0;
        for (int i = 1; i < 16; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Event bits: [0] ser_a, [1] ser_b, [2] ovf, [3] gpt, [4] rtc
    task automatic cycle(input bit w, input logic [1:0] a, input logic [15:0] d,
                         input logic [4:0] ev);
        logic [15:0] evb;
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        ser_a_evt = ev[0]; ser_b_evt = ev[1]; ser_ovf_evt = ev[2];
        gpt_evt = ev[3]; rtc_evt = ev[4];
        @(negedge clk);
        bus_wr = 1'b0;
        ser_a_evt = 1'b0; ser_b_evt = 1'b0; ser_ovf_evt = 1'b0;
        gpt_evt = 1'b0; rtc_evt = 1'b0;
        evb = '0;
        evb[4] = ev[0]; evb[5] = ev[1]; evb[3] = ev[2];
        evb[12] = ev[3]; evb[13] = ev[4];
        if (w) begin
            case (a)
                2'd1: e_mask = d & LB;
                2'd2: e_pend = e_pend & ~(d & LB);
                2'd3: e_frc  = d & LB;
                default: ;
            endcase
        end
        e_pend = e_pend | evb;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        check(req, int'(bus_rdata), int'(exp));
    endtask

    task automatic lvl(input string req);
        check(req, int'(irq_level), top_bit((e_pend | e_frc) & e_mask));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values during reset
        check("R1 level in reset", int'(irq_level), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1 pend", 2'd0, 16'h0);
        rd("R1 mask", 2'd1, 16'h0);
        rd("R1 force", 2'd3, 16'h0);
        check("R1 level after reset", int'(irq_level), 0);

        // R5 R6 R9: walking-one read-back, bit 0 dropped
        for (int k = 0; k < 16; k++) begin
            cycle(1'b1, 2'd1, 16'(1) << k, 5'b0);
            rd("R5 mask readback", 2'd1, (16'(1) << k) & LB);
            cycle(1'b1, 2'd3, 16'(1) << k, 5'b0);
            rd("R6 force readback", 2'd3, (16'(1) << k) & LB);
            rd("R6 force leaves pend", 2'd0, 16'h0);
        end
        cycle(1'b1, 2'd1, 16'h0001, 5'b0);
        rd("R9 mask bit0", 2'd1, 16'h0);

        // R7: all pairs of forced levels with full mask
        cycle(1'b1, 2'd1, 16'hFFFF, 5'b0);
        for (int i = 1; i < 16; i++) begin
            for (int j = 1; j < 16; j++) begin
                cycle(1'b1, 2'd3, (16'(1) << i) | (16'(1) << j), 5'b0);
                check("R7 pair priority", int'(irq_level), (i > j) ? i : j);
            end
        end
        // R7: full force, single mask bit
        cycle(1'b1, 2'd3, 16'hFFFF, 5'b0);
        for (int k = 0; k < 16; k++) begin
            cycle(1'b1, 2'd1, 16'(1) << k, 5'b0);
            check("R7 mask selects", int'(irq_level), k);
        end

        // R10: level holds the old value until the write edge
        cycle(1'b1, 2'd1, 16'hFFFF, 5'b0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0;
        #1;
        check("R10 before edge", int'(irq_level), 15);
        @(negedge clk);
        bus_wr = 1'b0;
        e_mask = 16'h0;
        check("R10 after edge", int'(irq_level), 0);

        // R2: each source alone, level follows
        cycle(1'b1, 2'd3, 16'h0, 5'b0);
        cycle(1'b1, 2'd1, 16'hFFFF, 5'b0);
        cycle(1'b0, 2'd0, 16'h0, 5'b00100);
        rd("R2 overrun sets level 3", 2'd0, 16'h0008);
        lvl("R2 level 3");
        cycle(1'b0, 2'd0, 16'h0, 5'b00001);
        rd("R2 serial A sets level 4", 2'd0, 16'h0018);
        lvl("R2 level 4");
        cycle(1'b0, 2'd0, 16'h0, 5'b00010);
        rd("R2 serial B sets level 5", 2'd0, 16'h0038);
        cycle(1'b0, 2'd0, 16'h0, 5'b01000);
        rd("R2 gp timer sets level 12", 2'd0, 16'h1038);
        cycle(1'b0, 2'd0, 16'h0, 5'b10000);
        rd("R2 rtc sets level 13", 2'd0, 16'h3038);
        lvl("R2 level 13");
        repeat (3) cycle(1'b0, 2'd0, 16'h0, 5'b0);
        rd("R2 pending holds", 2'd0, 16'h3038);

        // R8: write to pending ignored
        cycle(1'b1, 2'd0, 16'h0000, 5'b0);
        rd("R8 pend write ignored", 2'd0, 16'h3038);
        cycle(1'b1, 2'd0, 16'hFFFF, 5'b0);
        rd("R8 pend write ignored ones", 2'd0, 16'h3038);

        // R3: selective clear
        cycle(1'b1, 2'd2, 16'h2010, 5'b0);
        rd("R3 selective clear", 2'd0, 16'h1028);
        lvl("R3 level after clear");
        rd("R3 clear reads zero", 2'd2, 16'h0);
        cycle(1'b1, 2'd2, 16'hFFFF, 5'b0);
        rd("R3 clear all", 2'd0, 16'h0);
        lvl("R3 level idle");

        // R4: clear and event collide on level 4
        cycle(1'b1, 2'd2, 16'h0010, 5'b00001);
        rd("R4 event wins", 2'd0, 16'h0010);
        lvl("R4 level");
        cycle(1'b1, 2'd2, 16'hFFFF, 5'b10000);
        rd("R4 rtc survives full clear", 2'd0, 16'h2000);
        lvl("R4 level 13");

        // R6: forced level masked off, then combined with pending
        cycle(1'b1, 2'd3, 16'h8000, 5'b0);
        lvl("R6 force dominates");
        rd("R6 pend untouched", 2'd0, 16'h2000);
        cycle(1'b1, 2'd1, 16'h7FFF, 5'b0);
        lvl("R6 forced bit masked");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule